// File: doc/BRIEF.md
# Programmable Timeout Timer with Prescaler

This block is a countdown-style timeout timer for a small microcontroller. A base tick arrives from outside. It can pass through an optional divide-by-100 prescaler chain, or it can go straight to the final counter when the prescaler is bypassed. The final 8-bit counter counts these advance events. When the count reaches the programmed threshold, the block raises a sticky expiry flag and starts counting again from zero. A threshold of zero stands for a full 256-event period.

Software reaches the timer through a byte-wide register interface with three registers:
- a control register, which holds the interrupt enable, the prescaler select and the expiry flag;
- a read/write threshold register;
- a read-only view of the prescaler chain.

The interrupt request is a level signal. It goes to an external interrupt status register and stays high while the flag is set and interrupts are enabled.

Top module: `tmoTimer`

## Requirements
- R1: After reset, the control register (address 0) reads 00h, the threshold (address 1) reads 00h, the chain (address 2) reads 00h, and irqReq is 0.
- R2: A write to address 1 stores the byte as the threshold, and reading address 1 returns it.
- R3: With the prescaler bypassed (control bit 1 = 0), each baseTick advances the final counter by one. The flag (control bit 2) becomes visible in the cycle after the threshold-th advance, and the counter then restarts from zero.
- R4: A threshold of 00h makes expiry happen on the 256th advance.
- R5: With control bit 1 = 1, each baseTick increments the chain. On the tick that would make the chain 100, it wraps to 0 and advances the final counter once.
- R6: Address 2 returns the chain value in bits 6:0 with bit 7 reading 0, and writes to address 2 are ignored.
- R7: The flag stays set until a write to address 0 has bit 2 = 1. If expiry and such a clearing write occur in the same cycle, the flag remains set.
- R8: A write to address 1 clears the final counter and the chain. If an advance falls in the same cycle, the write wins and no expiry happens.
- R9: irqReq is high exactly while the flag and the interrupt enable (control bit 0) are both 1.
- R10: Control bits 7:3 read 0 whatever was written, and address 3 reads 00h.
- R11: While the prescaler is bypassed, the chain is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baseTick | input | 1 | One-cycle timer base tick |
| busAddr | input | 2 | Register address (0 control, 1 threshold, 2 chain) |
| busWrEn | input | 1 | Register write strobe |
| busWrData | input | 8 | Register write data |
| busRdData | output | 8 | Register read data for busAddr (combinational) |
| irqReq | output | 1 | Level interrupt request |

## Verification
Two coincidences matter for this block:
- An expiry can land in the same cycle as a software write that clears the flag.
- An advance can land in the same cycle as a threshold write that restarts the count.

The bench provokes both cases on purpose. It runs the counter to one short of the threshold, then issues the tick together with the write. A behavioural model applies the stated priorities, set-wins for the flag and restart-wins for the threshold write. The readback and irqReq are compared against that model on every clock, including the cycles right after the collision.

// File: rtl/tmoPkg.sv
package tmoPkg;
  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_THRESH = 2'd1;
  localparam logic [1:0] ADDR_CHAIN  = 2'd2;

  localparam int BIT_IEN   = 0;
  localparam int BIT_PRESC = 1;
  localparam int BIT_FLAG  = 2;

  typedef struct packed {
    logic restart;     // threshold write: clear counter and chain
    logic tick;        // base tick
    logic prescaleOn;  // route ticks through the divide chain
  } tmoStrobeT;
endpackage

// File: rtl/tmoDatapath.sv
module tmoDatapath
  import tmoPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_N  = 100,
  localparam int CHAIN_W = $clog2(DIV_N)
) (
  input  logic               clk,
  input  logic               rstN,
  input  tmoStrobeT          strb,
  input  logic [DATA_W-1:0]  thresh,
  output logic [CHAIN_W-1:0] chainVal,
  output logic               termHit
);
  logic [CHAIN_W-1:0] chain;
  logic [DATA_W-1:0]  count;
  logic chainWrap, advance, atLimit;

  assign chainWrap = (chain == CHAIN_W'(DIV_N - 1));
  // thresh - 1 wraps to all-ones for a zero threshold: full-range period
  assign atLimit   = (count == (thresh - 1'b1));

  always_comb begin
    advance = 1'b0;
    if (!strb.restart && strb.tick)
      advance = strb.prescaleOn ? chainWrap : 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                chain <= '0;
    else if (strb.restart || !strb.prescaleOn) chain <= '0;
    else if (strb.tick)                       chain <= chainWrap ? '0 : chain + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             count <= '0;
    else if (strb.restart) count <= '0;
    else if (advance)      count <= atLimit ? '0 : count + 1'b1;
  end

  assign chainVal = chain;
  assign termHit  = advance && atLimit;

  p_chain_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    chain < CHAIN_W'(DIV_N));
  p_restart_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |=> (chain == '0) && (count == '0));
  p_count_below_thresh_r3: assert property (@(posedge clk) disable iff (!rstN)
    (thresh != '0) |-> (count < thresh));
  p_bypass_chain_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strb.prescaleOn |=> (chain == '0));
endmodule

// File: rtl/tmoCtrl.sv
module tmoCtrl
  import tmoPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CHAIN_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               baseTick,
  input  logic [1:0]         busAddr,
  input  logic               busWrEn,
  input  logic [DATA_W-1:0]  busWrData,
  input  logic [CHAIN_W-1:0] chainVal,
  input  logic               termHit,
  output tmoStrobeT          strb,
  output logic [DATA_W-1:0]  thresh,
  output logic [DATA_W-1:0]  busRdData,
  output logic               irqReq
);
  logic ienReg, prescReg, flagReg;
  logic ctrlWr, threshWr, clearReq;

  assign ctrlWr   = busWrEn && (busAddr == ADDR_CTRL);
  assign threshWr = busWrEn && (busAddr == ADDR_THRESH);
  assign clearReq = ctrlWr && busWrData[BIT_FLAG];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ienReg   <= 1'b0;
      prescReg <= 1'b0;
      thresh   <= '0;
    end else begin
      if (ctrlWr) begin
        ienReg   <= busWrData[BIT_IEN];
        prescReg <= busWrData[BIT_PRESC];
      end
      if (threshWr) thresh <= busWrData;
    end
  end

  // expiry has priority over a clearing write in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         flagReg <= 1'b0;
    else if (termHit)  flagReg <= 1'b1;
    else if (clearReq) flagReg <= 1'b0;
  end

  always_comb begin
    strb.restart    = threshWr;
    strb.tick       = baseTick;
    strb.prescaleOn = prescReg;
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_CTRL: begin
        busRdData[BIT_IEN]   = ienReg;
        busRdData[BIT_PRESC] = prescReg;
        busRdData[BIT_FLAG]  = flagReg;
      end
      ADDR_THRESH: busRdData = thresh;
      ADDR_CHAIN:  busRdData = {{(DATA_W-CHAIN_W){1'b0}}, chainVal};
      default:     busRdData = '0;
    endcase
  end

  assign irqReq = flagReg && ienReg;

  p_hit_sets_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    termHit |=> flagReg);
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (flagReg && !clearReq) |=> flagReg);
  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ienReg |-> !irqReq);
endmodule

// File: rtl/tmoTimer.sv
module tmoTimer
  import tmoPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_N  = 100,
  localparam int CHAIN_W = $clog2(DIV_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseTick,
  input  logic [1:0]        busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqReq
);
  tmoStrobeT          strb;
  logic [DATA_W-1:0]  thresh;
  logic [CHAIN_W-1:0] chainVal;
  logic               termHit;

  tmoCtrl #(.DATA_W(DATA_W), .CHAIN_W(CHAIN_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .chainVal(chainVal),
    .termHit(termHit), .strb(strb), .thresh(thresh),
    .busRdData(busRdData), .irqReq(irqReq)
  );

  tmoDatapath #(.DATA_W(DATA_W), .DIV_N(DIV_N)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .thresh(thresh),
    .chainVal(chainVal), .termHit(termHit)
  );

  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_CTRL) |-> (busRdData[DATA_W-1:3] == '0));
endmodule

// File: tb/tmoTimer_tb.sv
`timescale 1ns/1ps
module tmoTimer_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic baseTick = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic busWrEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic irqReq;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  tmoTimer dut_i (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .irqReq(irqReq)
  );

  // behavioural reference model
  int mThr = 0, mCnt = 0, mChain = 0;
  bit mIen = 0, mPres = 0, mFlag = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mThr = 0; mCnt = 0; mChain = 0; mIen = 0; mPres = 0; mFlag = 0;
    end else begin
      bit adv, setF;
      int lim;
      adv = 0; setF = 0;
      if (busWrEn && busAddr == 2'd1) begin
        mThr = busWrData; mCnt = 0; mChain = 0;
      end else begin
        if (!mPres) mChain = 0;
        else if (baseTick) begin
          if (mChain == 99) begin mChain = 0; adv = 1; end
          else mChain = mChain + 1;
        end
        if (baseTick && !mPres) adv = 1;
        if (adv) begin
          lim = (mThr == 0) ? 256 : mThr;
          if (mCnt + 1 == lim) begin mCnt = 0; setF = 1; end
          else mCnt = mCnt + 1;
        end
      end
      if (setF) mFlag = 1;
      else if (busWrEn && busAddr == 2'd0 && busWrData[2]) mFlag = 0;
      if (busWrEn && busAddr == 2'd0) begin
        mIen = busWrData[0]; mPres = busWrData[1];
      end
    end
  end

  function automatic logic [7:0] mRead(input logic [1:0] a);
    case (a)
      2'd0: return {5'b0, mFlag, mPres, mIen};
      2'd1: return mThr[7:0];
      2'd2: return mChain[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", curReq, what, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic [1:0] a, input logic w, input logic [7:0] d);
    logic [7:0] e;
    baseTick = t; busAddr = a; busWrEn = w; busWrData = d;
    @(negedge clk);
    e = mRead(a);
    check(busRdData == e, "rdData", busRdData, e);
    check(irqReq == (mFlag && mIen), "irqReq", irqReq, mFlag && mIen);
  endtask

  task automatic ticks(input int n, input logic [1:0] a);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, a, 1'b0, 8'h00);
      cyc(1'b0, a, 1'b0, 8'h00);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state, R10 address 3
    curReq = "R1";
    for (int a = 0; a < 4; a++) cyc(1'b0, a[1:0], 1'b0, 8'h00);
    check(busRdData == 8'h00 && irqReq == 1'b0, "reset addr3/irq", busRdData, 0);

    // R2 threshold read/write
    curReq = "R2";
    cyc(1'b0, 2'd1, 1'b1, 8'hA5); cyc(1'b0, 2'd1, 1'b0, 8'h00);
    cyc(1'b0, 2'd1, 1'b1, 8'h05); cyc(1'b0, 2'd1, 1'b0, 8'h00);

    // R3 bypass expiry after 5 ticks, R9 irq with enable
    curReq = "R3";
    cyc(1'b0, 2'd0, 1'b1, 8'h01);
    ticks(4, 2'd0);
    check(busRdData[2] == 1'b0, "no flag after 4", busRdData[2], 0);
    ticks(1, 2'd0);
    check(busRdData[2] == 1'b1, "flag after 5", busRdData[2], 1);
    curReq = "R9";
    check(irqReq == 1'b1, "irq set", irqReq, 1);
    cyc(1'b0, 2'd0, 1'b1, 8'h00);  // disable, flag kept
    check(irqReq == 1'b0, "irq masked", irqReq, 0);
    cyc(1'b0, 2'd0, 1'b1, 8'h01);
    // R7 clear
    curReq = "R7";
    cyc(1'b0, 2'd0, 1'b1, 8'h05); cyc(1'b0, 2'd0, 1'b0, 8'h00);
    check(busRdData[2] == 1'b0 && irqReq == 1'b0, "cleared", busRdData, 1);
    // R3 restart: next expiry after 5 more
    curReq = "R3";
    ticks(5, 2'd0);

    // R4 zero threshold = 256
    curReq = "R4";
    cyc(1'b0, 2'd0, 1'b1, 8'h05);
    cyc(1'b0, 2'd1, 1'b1, 8'h00);
    ticks(255, 2'd0);
    check(busRdData[2] == 1'b0, "no flag at 255", busRdData[2], 0);
    ticks(1, 2'd0);
    check(busRdData[2] == 1'b1, "flag at 256", busRdData[2], 1);

    // R11 chain held at 0 while bypassed
    curReq = "R11";
    ticks(3, 2'd2);
    check(busRdData == 8'h00, "chain bypassed", busRdData, 0);

    // R5/R6 prescaler, threshold 2, read chain
    curReq = "R5";
    cyc(1'b0, 2'd0, 1'b1, 8'h07);  // ien, presc, clear
    cyc(1'b0, 2'd1, 1'b1, 8'h02);
    for (int i = 0; i < 99; i++) cyc(1'b1, 2'd2, 1'b0, 8'h00);
    check(busRdData == 8'd99, "chain at 99", busRdData, 99);
    cyc(1'b1, 2'd2, 1'b0, 8'h00);
    check(busRdData == 8'd0, "chain wrap", busRdData, 0);
    for (int i = 0; i < 100; i++) cyc(1'b1, 2'd0, 1'b0, 8'h00);
    check(busRdData[2] == 1'b1, "flag after 200 ticks", busRdData[2], 1);
    curReq = "R6";
    ticks(10, 2'd2);
    cyc(1'b0, 2'd2, 1'b1, 8'hFF); cyc(1'b0, 2'd2, 1'b0, 8'h00);
    check(busRdData == 8'd10, "chain write ignored", busRdData, 10);

    // R10 reserved control bits
    curReq = "R10";
    cyc(1'b0, 2'd0, 1'b1, 8'hFC); cyc(1'b0, 2'd0, 1'b0, 8'h00);
    cyc(1'b0, 2'd3, 1'b1, 8'hFF); cyc(1'b0, 2'd3, 1'b0, 8'h00);

    // R7 coincidence: expiry with clearing write -> flag stays
    curReq = "R7";
    cyc(1'b0, 2'd0, 1'b1, 8'h05);
    cyc(1'b0, 2'd1, 1'b1, 8'h03);
    ticks(2, 2'd0);
    cyc(1'b1, 2'd0, 1'b1, 8'h05);
    check(busRdData[2] == 1'b1, "set wins over clear", busRdData[2], 1);
    cyc(1'b0, 2'd0, 1'b1, 8'h05);

    // R8 coincidence: threshold write with terminal advance
    curReq = "R8";
    ticks(2, 2'd0);
    cyc(1'b1, 2'd1, 1'b1, 8'h03);
    cyc(1'b0, 2'd0, 1'b0, 8'h00);
    check(busRdData[2] == 1'b0, "write wins, no expiry", busRdData[2], 0);
    ticks(2, 2'd0);
    check(busRdData[2] == 1'b0, "restarted count", busRdData[2], 0);
    ticks(1, 2'd0);
    check(busRdData[2] == 1'b1, "expiry after 3", busRdData[2], 1);
    // R8 chain cleared by threshold write
    cyc(1'b0, 2'd0, 1'b1, 8'h06);
    ticks(7, 2'd2);
    cyc(1'b0, 2'd1, 1'b1, 8'h09);
    cyc(1'b0, 2'd2, 1'b0, 8'h00);
    check(busRdData == 8'h00, "chain cleared", busRdData, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule